// File: doc/BRIEF.md
# Interrupt-Triggered Peripheral DMA Channel

This block is one DMA channel that rides on the interrupt request path of a single peripheral. When the peripheral raises an event, or software sets the pending flag, and the channel is armed, the event becomes a DMA request instead of an ordinary interrupt. The request competes against the CPU's current priority level. It is serviced only at an instruction boundary, and never while the highest-level interrupt handler is running.

Each grant moves exactly one data item. The item goes between the peripheral data register and either main memory or the register file, at the location held by an up-counting address pointer, and a down-counting transaction counter is decremented. When the counter runs out, the channel disarms itself and raises an end-of-block interrupt. That interrupt stays up until the CPU acknowledges it.

The channel is set up through a load strobe. The strobe carries the start address, the item count and two register-file pointer bytes. Bit 0 of each pointer byte carries a control bit.

Top module: `irq_dma_channel`

## Requirements
- R1: A transfer is started only when the pending flag is set and the channel is armed. The pending flag is set by `periph_evt` or by `soft_pend`.
- R2: A pending, armed request is granted only in a cycle with `instr_end` high, `top_busy` low and `src_prio >= cpu_prio` (unsigned). A request with `src_prio` equal to `cpu_prio` is granted.
- R3: Each grant performs exactly one bus transaction, at `bus_addr = {segment, pointer}`. The pointer then advances by one, and the pending flag is cleared, so the next transaction needs a new event. `bus_req` and `bus_addr` hold until `bus_ack`.
- R4: With `periph_rx`=1 the transaction is a bus write (`bus_we`=1) of the `periph_rdata` value sampled at grant. With `periph_rx`=0 it is a bus read, and `bus_rdata` at the ack cycle appears on `periph_wdata` with a one-cycle `periph_we` pulse on the following cycle.
- R5: Bit 0 of `cfg_cnt_ptr` selects the target space: 0 gives memory (`bus_space`=0), 1 gives the register file (`bus_space`=1).
- R6: Bit 0 of `cfg_adr_ptr` selects the upper address byte: 0 takes `seg_a`, 1 takes `seg_b`.
- R7: The transaction that takes the counter to zero disarms the channel and sets the end-of-block pending flag. `eob_irq` = pending AND `eob_irq_en` AND `src_prio >= cpu_prio`.
- R8: The end-of-block pending flag stays set until `irq_ack`, or until a new accepted load.
- R9: An accepted load with a count of zero sets the end-of-block flag at once, leaves the channel disarmed and causes no transfer.
- R10: A load whose `cfg_cnt_ptr` or `cfg_adr_ptr` exceeds 8'hDF is rejected. `cfg_reject` pulses for one cycle, and the channel state and end-of-block flag are unchanged.
- R11: After reset, `bus_req`, `periph_we`, `eob_irq` and `cfg_reject` are low and the channel is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load strobe for channel setup |
| cfg_addr | input | 16 | Start address pointer |
| cfg_count | input | 16 | Number of items to move |
| cfg_cnt_ptr | input | 8 | Register-file location of counter; bit 0 = space select |
| cfg_adr_ptr | input | 8 | Register-file location of pointer; bit 0 = segment select |
| cfg_reject | output | 1 | One-cycle pulse on a rejected load |
| periph_evt | input | 1 | Peripheral hardware event |
| soft_pend | input | 1 | Software sets the pending flag |
| periph_rx | input | 1 | 1 = peripheral to bus, 0 = bus to peripheral |
| periph_rdata | input | 8 | Peripheral data register (receive) |
| periph_wdata | output | 8 | Data delivered to peripheral (transmit) |
| periph_we | output | 1 | Write strobe to peripheral |
| src_prio | input | 3 | Priority level of this source |
| cpu_prio | input | 3 | Current CPU priority level |
| instr_end | input | 1 | Instruction boundary |
| top_busy | input | 1 | Top-level interrupt service in progress |
| seg_a | input | 8 | Upper address byte, choice 0 |
| seg_b | input | 8 | Upper address byte, choice 1 |
| bus_req | output | 1 | Bus transaction request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_space | output | 1 | 0 = memory, 1 = register file |
| bus_addr | output | 24 | Extended bus address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Bus acknowledge, data phase |
| bus_rdata | input | 8 | Read data, valid with ack |
| eob_irq_en | input | 1 | End-of-block interrupt mask |
| irq_ack | input | 1 | CPU acknowledge of end-of-block |
| eob_irq | output | 1 | End-of-block interrupt request |

## Verification
The bench builds the channel with its defaults: 16-bit pointer and counter, 8-bit data, 3-bit priorities and a register-file limit of 8'hDF. Block counts of zero to three items are enough to reach the counter-exhaustion path, the zero-count start and the disarmed state that follows. The 3-bit priority range makes the lower, equal and higher comparisons and the top-level-busy gate cheap to cover as table rows. A pointer byte of 8'hE0 sits just above the limit and exercises rejection.

// File: rtl/irqdma_pkg.sv
package irqdma_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUS  = 1'b1
  } xfer_state_t;

endpackage

// File: rtl/irqdma_arb.sv
module irqdma_arb #(
  parameter int PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_evt,
  input  logic              sw_set,
  input  logic              armed,
  input  logic              idle,
  input  logic [PRIO_W-1:0] src_prio,
  input  logic [PRIO_W-1:0] cpu_prio,
  input  logic              instr_end,
  input  logic              top_busy,
  output logic              grant,
  output logic              pend
);

  logic pend_q, pend_d;
  logic prio_ok;

  always_comb begin
    prio_ok = (src_prio >= cpu_prio);
    grant   = pend_q & armed & idle & instr_end & ~top_busy & prio_ok;
    pend_d  = (pend_q & ~grant) | hw_evt | sw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;

  // R3: a grant with no fresh event leaves nothing pending
  assert_one_per_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !hw_evt && !sw_set) |=> !pend_q);

endmodule

// File: rtl/irqdma_ptr.sv
module irqdma_ptr #(
  parameter int              ADDR_W = 16,
  parameter int              CNT_W  = 16,
  parameter int              PTR_W  = 8,
  parameter logic [PTR_W-1:0] RF_TOP = 8'hDF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [PTR_W-1:0]  cfg_cnt_ptr,
  input  logic [PTR_W-1:0]  cfg_adr_ptr,
  input  logic              step,
  input  logic              irq_ack,
  output logic [ADDR_W-1:0] addr,
  output logic              armed,
  output logic              space,
  output logic              seg_sel,
  output logic              eob_pend,
  output logic              reject
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0]  CNT_ZERO = '0;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic armed_q, armed_d, space_q, space_d, seg_q, seg_d;
  logic eob_q, eob_d, rej_q, rej_d;
  logic ptr_ok, load_acc, load_bad, last, zero_load, finish;

  always_comb begin
    ptr_ok    = (cfg_cnt_ptr <= RF_TOP) && (cfg_adr_ptr <= RF_TOP);
    load_acc  = cfg_load & idle & ptr_ok;
    load_bad  = cfg_load & idle & ~ptr_ok;
    last      = (cnt_q == CNT_ONE);
    zero_load = load_acc & (cfg_count == CNT_ZERO);
    finish    = step & last;

    addr_d  = addr_q;
    cnt_d   = cnt_q;
    armed_d = armed_q;
    space_d = space_q;
    seg_d   = seg_q;
    eob_d   = eob_q;
    rej_d   = load_bad;

    if (load_acc) begin
      addr_d  = cfg_addr;
      cnt_d   = cfg_count;
      armed_d = ~zero_load;
      space_d = cfg_cnt_ptr[0];
      seg_d   = cfg_adr_ptr[0];
    end else if (step) begin
      addr_d = addr_q + ADDR_ONE;
      cnt_d  = cnt_q - CNT_ONE;
      if (last) armed_d = 1'b0;
    end

    if (zero_load || finish)   eob_d = 1'b1;
    else if (irq_ack || load_acc) eob_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      space_q <= 1'b0;
      seg_q   <= 1'b0;
      eob_q   <= 1'b0;
      rej_q   <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      space_q <= space_d;
      seg_q   <= seg_d;
      eob_q   <= eob_d;
      rej_q   <= rej_d;
    end
  end

  assign addr     = addr_q;
  assign armed    = armed_q;
  assign space    = space_q;
  assign seg_sel  = seg_q;
  assign eob_pend = eob_q;
  assign reject   = rej_q;

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (addr_q == $past(addr_q) + ADDR_ONE));

  assert_disarm_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last) |=> (!armed_q && eob_q));

  assert_eob_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eob_q && !irq_ack && !cfg_load) |=> eob_q);

  assert_reject_keeps_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rej_q |-> (armed_q == $past(armed_q)));

endmodule

// File: rtl/irqdma_xfer.sv
module irqdma_xfer
  import irqdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SEG_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    grant,
  input  logic                    rx_mode,
  input  logic                    space,
  input  logic                    seg_sel,
  input  logic [SEG_W-1:0]        seg_a,
  input  logic [SEG_W-1:0]        seg_b,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       periph_rdata,
  input  logic                    bus_ack,
  input  logic [DATA_W-1:0]       bus_rdata,
  output logic                    bus_req,
  output logic                    bus_we,
  output logic                    bus_space,
  output logic [SEG_W+ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0]       bus_wdata,
  output logic                    periph_we,
  output logic [DATA_W-1:0]       periph_wdata,
  output logic                    step,
  output logic                    idle
);

  xfer_state_t       state_q, state_d;
  logic              dir_q, dir_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              pwe_q, pwe_d;
  logic [DATA_W-1:0] pwd_q, pwd_d;

  always_comb begin
    state_d = state_q;
    dir_d   = dir_q;
    data_d  = data_q;
    step    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (grant) begin
        state_d = ST_BUS;
        dir_d   = rx_mode;
        data_d  = periph_rdata;
      end
      ST_BUS: if (bus_ack) begin
        state_d = ST_IDLE;
        step    = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
    pwe_d = step & ~dir_q;
    pwd_d = (step & ~dir_q) ? bus_rdata : pwd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dir_q   <= 1'b0;
      data_q  <= '0;
      pwe_q   <= 1'b0;
      pwd_q   <= '0;
    end else begin
      state_q <= state_d;
      dir_q   <= dir_d;
      data_q  <= data_d;
      pwe_q   <= pwe_d;
      pwd_q   <= pwd_d;
    end
  end

  assign idle         = (state_q == ST_IDLE);
  assign bus_req      = (state_q == ST_BUS);
  assign bus_we       = dir_q;
  assign bus_space    = space;
  assign bus_addr     = {(seg_sel ? seg_b : seg_a), addr};
  assign bus_wdata    = data_q;
  assign periph_we    = pwe_q;
  assign periph_wdata = pwd_q;

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr)));

  assert_tx_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    periph_we |-> $past(bus_req && bus_ack && !bus_we));

endmodule

// File: rtl/irq_dma_channel.sv
module irq_dma_channel #(
  parameter int              ADDR_W = 16,
  parameter int              CNT_W  = 16,
  parameter int              DATA_W = 8,
  parameter int              SEG_W  = 8,
  parameter int              PRIO_W = 3,
  parameter int              PTR_W  = 8,
  parameter logic [PTR_W-1:0] RF_TOP = 8'hDF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_load,
  input  logic [ADDR_W-1:0]       cfg_addr,
  input  logic [CNT_W-1:0]        cfg_count,
  input  logic [PTR_W-1:0]        cfg_cnt_ptr,
  input  logic [PTR_W-1:0]        cfg_adr_ptr,
  output logic                    cfg_reject,
  input  logic                    periph_evt,
  input  logic                    soft_pend,
  input  logic                    periph_rx,
  input  logic [DATA_W-1:0]       periph_rdata,
  output logic [DATA_W-1:0]       periph_wdata,
  output logic                    periph_we,
  input  logic [PRIO_W-1:0]       src_prio,
  input  logic [PRIO_W-1:0]       cpu_prio,
  input  logic                    instr_end,
  input  logic                    top_busy,
  input  logic [SEG_W-1:0]        seg_a,
  input  logic [SEG_W-1:0]        seg_b,
  output logic                    bus_req,
  output logic                    bus_we,
  output logic                    bus_space,
  output logic [SEG_W+ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0]       bus_wdata,
  input  logic                    bus_ack,
  input  logic [DATA_W-1:0]       bus_rdata,
  input  logic                    eob_irq_en,
  input  logic                    irq_ack,
  output logic                    eob_irq
);

  logic              grant, pend, armed, idle, step;
  logic              space, seg_sel, eob_pend;
  logic [ADDR_W-1:0] addr;

  irqdma_arb #(.PRIO_W(PRIO_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_evt    (periph_evt),
    .sw_set    (soft_pend),
    .armed     (armed),
    .idle      (idle),
    .src_prio  (src_prio),
    .cpu_prio  (cpu_prio),
    .instr_end (instr_end),
    .top_busy  (top_busy),
    .grant     (grant),
    .pend      (pend)
  );

  irqdma_ptr #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PTR_W(PTR_W), .RF_TOP(RF_TOP)
  ) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle        (idle),
    .cfg_load    (cfg_load),
    .cfg_addr    (cfg_addr),
    .cfg_count   (cfg_count),
    .cfg_cnt_ptr (cfg_cnt_ptr),
    .cfg_adr_ptr (cfg_adr_ptr),
    .step        (step),
    .irq_ack     (irq_ack),
    .addr        (addr),
    .armed       (armed),
    .space       (space),
    .seg_sel     (seg_sel),
    .eob_pend    (eob_pend),
    .reject      (cfg_reject)
  );

  irqdma_xfer #(
    .ADDR_W(ADDR_W), .SEG_W(SEG_W), .DATA_W(DATA_W)
  ) u_xfer (
    .clk          (clk),
    .rst_n        (rst_n),
    .grant        (grant),
    .rx_mode      (periph_rx),
    .space        (space),
    .seg_sel      (seg_sel),
    .seg_a        (seg_a),
    .seg_b        (seg_b),
    .addr         (addr),
    .periph_rdata (periph_rdata),
    .bus_ack      (bus_ack),
    .bus_rdata    (bus_rdata),
    .bus_req      (bus_req),
    .bus_we       (bus_we),
    .bus_space    (bus_space),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .periph_we    (periph_we),
    .periph_wdata (periph_wdata),
    .step         (step),
    .idle         (idle)
  );

  assign eob_irq = eob_pend & eob_irq_en & (src_prio >= cpu_prio);

  assert_req_at_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(instr_end && !top_busy && (src_prio >= cpu_prio)));

  assert_req_needs_pend_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(pend && armed));

endmodule

// File: tb/tb_irq_dma_channel.sv
module tb_irq_dma_channel;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_load;
  logic [15:0] cfg_addr, cfg_count;
  logic [7:0]  cfg_cnt_ptr, cfg_adr_ptr;
  logic        cfg_reject;
  logic        periph_evt, soft_pend, periph_rx;
  logic [7:0]  periph_rdata, periph_wdata;
  logic        periph_we;
  logic [2:0]  src_prio, cpu_prio;
  logic        instr_end, top_busy;
  logic [7:0]  seg_a, seg_b;
  logic        bus_req, bus_we, bus_space;
  logic [23:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        bus_ack;
  logic        eob_irq_en, irq_ack, eob_irq;

  int n_chk = 0, n_fail = 0;
  int txn_cnt = 0, pw_cnt = 0, rej_cnt = 0;
  logic [23:0] last_addr;
  logic [7:0]  last_wdata, last_pw;
  logic        last_we, last_space;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  irq_dma_channel dut (.*);

  // bus model: ack on the negedge after a request, read data derived from address
  assign bus_rdata = bus_addr[7:0] ^ 8'h5A;
  always @(negedge clk) bus_ack <= bus_req & ~bus_ack;

  always @(posedge clk) begin
    if (rst_n) begin
      if (bus_req && bus_ack) begin
        txn_cnt    <= txn_cnt + 1;
        last_addr  <= bus_addr;
        last_wdata <= bus_wdata;
        last_we    <= bus_we;
        last_space <= bus_space;
      end
      if (periph_we) begin
        pw_cnt  <= pw_cnt + 1;
        last_pw <= periph_wdata;
      end
      if (cfg_reject) rej_cnt <= rej_cnt + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_load = 0; cfg_addr = 0; cfg_count = 0;
    cfg_cnt_ptr = 0; cfg_adr_ptr = 0; periph_evt = 0; soft_pend = 0;
    periph_rx = 1; periph_rdata = 0; src_prio = 0; cpu_prio = 0;
    instr_end = 0; top_busy = 0; seg_a = 8'h7E; seg_b = 8'h3C;
    eob_irq_en = 1; irq_ack = 0; bus_ack = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic load(input logic [15:0] a, input logic [15:0] c,
                      input logic [7:0] cp, input logic [7:0] ap);
    cfg_load = 1; cfg_addr = a; cfg_count = c; cfg_cnt_ptr = cp; cfg_adr_ptr = ap;
    @(negedge clk);
    cfg_load = 0;
  endtask

  task automatic pulse_evt(input bit hw);
    if (hw) periph_evt = 1; else soft_pend = 1;
    @(negedge clk);
    periph_evt = 0; soft_pend = 0;
  endtask

  task automatic boundary(input bit ie);
    instr_end = ie;
    @(negedge clk);
    instr_end = 0;
    repeat (5) @(negedge clk);
  endtask

  // {hw, sw, arm, src[2:0], cpu[2:0], busy, ie, exp}
  localparam logic [11:0] VEC [8] = '{
    {1'b1, 1'b0, 1'b1, 3'd4, 3'd3, 1'b0, 1'b1, 1'b1}, // R1 R2 higher
    {1'b0, 1'b1, 1'b1, 3'd3, 3'd3, 1'b0, 1'b1, 1'b1}, // R1 R2 soft, equal
    {1'b1, 1'b0, 1'b1, 3'd2, 3'd5, 1'b0, 1'b1, 1'b0}, // R2 lower
    {1'b1, 1'b0, 1'b1, 3'd7, 3'd0, 1'b1, 1'b1, 1'b0}, // R2 top busy
    {1'b1, 1'b0, 1'b1, 3'd7, 3'd0, 1'b0, 1'b0, 1'b0}, // R2 no boundary
    {1'b0, 1'b0, 1'b1, 3'd7, 3'd0, 1'b0, 1'b1, 1'b0}, // R1 nothing pending
    {1'b1, 1'b0, 1'b0, 3'd7, 3'd0, 1'b0, 1'b1, 1'b0}, // R1 not armed
    {1'b0, 1'b1, 1'b1, 3'd0, 3'd0, 1'b0, 1'b1, 1'b1}  // R2 zero equals zero
  };

  initial begin
    int n0;
    do_reset();
    // R11 reset state
    check("R11 bus_req", bus_req, 0);
    check("R11 periph_we", periph_we, 0);
    check("R11 eob_irq", eob_irq, 0);
    check("R11 cfg_reject", cfg_reject, 0);
    n0 = txn_cnt; pulse_evt(1); boundary(1);
    check("R11 disarmed after reset", txn_cnt - n0, 0);

    for (int i = 0; i < 8; i++) begin
      logic [11:0] v;
      v = VEC[i];
      do_reset();
      src_prio = v[8:6]; cpu_prio = v[5:3]; top_busy = v[2];
      if (v[9]) load(16'h0400, 16'd4, 8'h10, 8'h20);
      if (v[11]) pulse_evt(1);
      if (v[10]) pulse_evt(0);
      n0 = txn_cnt;
      boundary(v[1]);
      check($sformatf("R1/R2 vector %0d", i), txn_cnt - n0, {31'd0, v[0]});
    end

    // R3 R5 R6 R7 R4: receive block of three to memory, segment A
    do_reset();
    src_prio = 3'd2; cpu_prio = 3'd1;
    load(16'h1230, 16'd3, 8'h10, 8'h20);
    for (int k = 0; k < 3; k++) begin
      periph_rdata = 8'hA0 + 8'(k);
      pulse_evt(1); n0 = txn_cnt; boundary(1);
      check("R3 one transaction", txn_cnt - n0, 1);
      check("R3 R6 address", last_addr, {8'h7E, 16'h1230 + 16'(k)});
      check("R4 rx write data", last_wdata, 8'hA0 + 8'(k));
      check("R4 rx is write", last_we, 1);
      check("R5 memory space", last_space, 0);
      check("R7 eob level", eob_irq, (k == 2) ? 1 : 0);
      if (k == 0) begin
        n0 = txn_cnt; boundary(1);
        check("R3 no repeat without event", txn_cnt - n0, 0);
      end
    end
    pulse_evt(1); n0 = txn_cnt; boundary(1);
    check("R7 disarmed after block", txn_cnt - n0, 0);
    repeat (4) @(negedge clk);
    check("R8 eob held", eob_irq, 1);
    irq_ack = 1; @(negedge clk); irq_ack = 0;
    check("R8 eob cleared by ack", eob_irq, 0);

    // R4 R5 R6: transmit from register file, segment B
    do_reset();
    periph_rx = 0;
    load(16'h00F0, 16'd2, 8'h11, 8'h21);
    n0 = pw_cnt;
    pulse_evt(0); boundary(1);
    check("R6 segment B address", last_addr, 24'h3C00F0);
    check("R5 register file space", last_space, 1);
    check("R4 tx is read", last_we, 0);
    check("R4 tx strobe count", pw_cnt - n0, 1);
    check("R4 tx data", last_pw, 8'hF0 ^ 8'h5A);

    // R9 zero count
    do_reset();
    load(16'h0100, 16'd0, 8'h10, 8'h20);
    check("R9 immediate eob", eob_irq, 1);
    pulse_evt(1); n0 = txn_cnt; boundary(1);
    check("R9 no transfer", txn_cnt - n0, 0);

    // R7 interrupt mask and priority gating of eob
    do_reset();
    eob_irq_en = 0;
    load(16'h0100, 16'd0, 8'h10, 8'h20);
    check("R7 masked eob", eob_irq, 0);
    eob_irq_en = 1; #1;
    check("R7 unmasked eob", eob_irq, 1);
    cpu_prio = 3'd1; #1;
    check("R7 eob below cpu level", eob_irq, 0);

    // R10 rejected pointer
    do_reset();
    n0 = rej_cnt;
    load(16'h0200, 16'd2, 8'hE0, 8'h20);
    repeat (2) @(negedge clk);
    check("R10 reject pulse", rej_cnt - n0, 1);
    check("R10 no eob", eob_irq, 0);
    pulse_evt(1); n0 = txn_cnt; boundary(1);
    check("R10 not armed", txn_cnt - n0, 0);
    n0 = rej_cnt;
    load(16'h0200, 16'd2, 8'hDF, 8'hDF);
    repeat (2) @(negedge clk);
    check("R10 limit accepted", rej_cnt - n0, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule